// File: doc/BRIEF.md
# Double-Buffered Audio Sample Player

The player keeps a table of 1024 audio samples, each 16 bits wide. The table is split into two halves of 512 entries. A producer writes samples through a plain write port on a fast write clock. A read pointer running on the slow sample-rate clock walks the table and presents one sample per sample clock. The producer refills one half while the pointer is playing from the other half.

Playback has three controls: a play strobe, a stop strobe and an unsigned step size. The step size is added to the read pointer on every sample clock while the player is running. The player reports a running flag and the half that the read pointer is currently in. That half indicator is also brought across to the write clock, so the producer can decide which half is free to overwrite without crossing clocks itself. The sample table is one dual-clock memory, written so that a block RAM with a resettable output register can be inferred.

Top module: `dbsp_player`

## Requirements
- R1: While `rst` is high at a sample-clock edge, that edge clears `playing`, `sample_out` and `half_sel` to 0 and moves the read position to entry 0. `rst` wins over every other control input.
- R2: If `play` is high and `stop` is low at a sample-clock edge, `playing` is 1 after that edge. The same edge presents the entry at the read position that was held before the edge.
- R3: While running, `sample_out` after each sample-clock edge holds the table entry at the read position from before that edge. The memory read therefore adds one clock of latency.
- R4: With `speed` = 1, the read position rises by one entry per sample clock while running, and wraps from 1023 back to 0.
- R5: `speed` is an unsigned step that is added modulo 1024 to the read position on each running clock. A `speed` of 0 holds the position, so the same entry is repeated.
- R6: A high `stop` at a sample-clock edge clears `playing` and forces `sample_out` to 0 from that edge on. The read position is held until the next play, and playback then resumes from the held position.
- R7: When `play` and `stop` are both high at the same edge, `stop` wins and `playing` is 0 after that edge.
- R8: `half_sel` is bit 9 of the read position: 0 for entries 0 to 511 and 1 for entries 512 to 1023.
- R9: `wr_half_sel` is `half_sel` after a two-stage synchroniser clocked by `wr_clk`. It equals `half_sel` within two write-clock edges, and `wr_rst` clears it to 0.
- R10: `wr_addr`, `wr_data` and `wr_en` are sampled on the rising edge of `wr_clk`. An entry is written only when `wr_en` is high, and an edge with `wr_en` low leaves the table unchanged.
- R11: Writes to the half that is not being played do not disturb the samples being played. After the read position crosses into the rewritten half, the new contents are played.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| smp_clk | input | 1 | Sample-rate clock for the read side |
| rst | input | 1 | Synchronous active-high reset, read side |
| play | input | 1 | Start or resume playback |
| stop | input | 1 | Halt playback and mute the output |
| speed | input | 4 | Unsigned step added to the read position |
| playing | output | 1 | High while playback is running |
| sample_out | output | 16 | Current sample, 0 when not running |
| half_sel | output | 1 | Half holding the read position (sample clock) |
| wr_clk | input | 1 | Fast write clock for the producer |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 10 | Entry to write |
| wr_data | input | 16 | Sample value to write |
| wr_half_sel | output | 1 | `half_sel` synchronised into the write clock |

## Verification
The bound checker checks the following on every clock:
- the reset values;
- that stop wins over play and mutes the output;
- that the read position is frozen whenever playback is idle or the step is zero;
- the reset value of the write-side half indicator.

Other behaviour needs table contents known to the bench, so only the directed scenarios can show it:
- the actual sample values;
- the one-clock read latency;
- the wrap from 1023 to 0;
- steps larger than one;
- the effect of a write with the strobe low;
- that refilling one half while the other plays is seen at the output only after the pointer crosses over.

// File: rtl/dbsp_pkg.sv
package dbsp_pkg;

  localparam int unsigned DEF_ADDR_W   = 10;
  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_SPEED_W  = 4;
  localparam int unsigned DEF_SYNC_N   = 2;

  typedef enum logic {
    RUN_IDLE   = 1'b0,
    RUN_ACTIVE = 1'b1
  } run_state_e;

endpackage

// File: rtl/dbsp_ram.sv
module dbsp_ram #(
  parameter int unsigned ADDR_W   = dbsp_pkg::DEF_ADDR_W,
  parameter int unsigned SAMPLE_W = dbsp_pkg::DEF_SAMPLE_W
) (
  input  logic                wr_clk,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic                rd_clk,
  input  logic                rd_clr,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] store [DEPTH];

  // write port: producer clock
  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      store[wr_addr] <= wr_data;
    end
  end

  // read port: registered output with synchronous clear (output-register reset)
  always_ff @(posedge rd_clk) begin
    if (rd_clr) begin
      rd_data <= '0;
    end else begin
      rd_data <= store[rd_addr];
    end
  end

endmodule

// File: rtl/dbsp_ctrl.sv
module dbsp_ctrl
  import dbsp_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned SPEED_W = DEF_SPEED_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               play,
  input  logic               stop,
  input  logic [SPEED_W-1:0] speed,
  output logic               playing,
  output logic               run_next,
  output logic [ADDR_W-1:0]  rd_addr
);

  run_state_e state_q, state_d;
  logic [ADDR_W-1:0] step_ext;

  assign step_ext = ADDR_W'(speed);

  // stop has priority over play; otherwise the state is kept
  always_comb begin
    state_d = state_q;
    if (stop) begin
      state_d = RUN_IDLE;
    end else if (play) begin
      state_d = RUN_ACTIVE;
    end
  end

  assign run_next = (state_d == RUN_ACTIVE) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RUN_IDLE;
      rd_addr <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == RUN_ACTIVE) begin
        rd_addr <= rd_addr + step_ext;   // wraps modulo table depth
      end
    end
  end

  assign playing = (state_q == RUN_ACTIVE);

endmodule

// File: rtl/dbsp_sync.sv
module dbsp_sync #(
  parameter int unsigned STAGES = dbsp_pkg::DEF_SYNC_N
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dbsp_player.sv
module dbsp_player
  import dbsp_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SPEED_W  = DEF_SPEED_W,
  parameter int unsigned SYNC_N   = DEF_SYNC_N
) (
  input  logic                smp_clk,
  input  logic                rst,
  input  logic                play,
  input  logic                stop,
  input  logic [SPEED_W-1:0]  speed,
  output logic                playing,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                half_sel,
  input  logic                wr_clk,
  input  logic                wr_rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                wr_half_sel
);

  localparam int unsigned HALF_BIT = ADDR_W - 1;

  logic [ADDR_W-1:0] rd_addr;
  logic              run_next;

  dbsp_ctrl #(
    .ADDR_W  (ADDR_W),
    .SPEED_W (SPEED_W)
  ) ctrl_i (
    .clk      (smp_clk),
    .rst      (rst),
    .play     (play),
    .stop     (stop),
    .speed    (speed),
    .playing  (playing),
    .run_next (run_next),
    .rd_addr  (rd_addr)
  );

  // output register clears whenever the next state is not running
  dbsp_ram #(
    .ADDR_W   (ADDR_W),
    .SAMPLE_W (SAMPLE_W)
  ) ram_i (
    .wr_clk  (wr_clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_clk  (smp_clk),
    .rd_clr  (!run_next),
    .rd_addr (rd_addr),
    .rd_data (sample_out)
  );

  assign half_sel = rd_addr[HALF_BIT];

  dbsp_sync #(
    .STAGES (SYNC_N)
  ) half_sync_i (
    .clk (wr_clk),
    .rst (wr_rst),
    .d   (half_sel),
    .q   (wr_half_sel)
  );

endmodule

// File: rtl/dbsp_player_chk.sv
module dbsp_player_chk #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned SPEED_W  = 4
) (
  input logic                smp_clk,
  input logic                rst,
  input logic                play,
  input logic                stop,
  input logic [SPEED_W-1:0]  speed,
  input logic                playing,
  input logic [SAMPLE_W-1:0] sample_out,
  input logic                half_sel,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic                wr_clk,
  input logic                wr_rst,
  input logic                wr_half_sel
);

  a_r1_reset_idle: assert property (@(posedge smp_clk)
    rst |=> (!playing && sample_out == '0 && !half_sel && rd_addr == '0));

  a_r2_play_sets: assert property (@(posedge smp_clk) disable iff (rst)
    (play && !stop) |=> playing);

  a_r7_stop_wins: assert property (@(posedge smp_clk) disable iff (rst)
    stop |=> (!playing && sample_out == '0));

  a_r6_idle_muted: assert property (@(posedge smp_clk) disable iff (rst)
    !playing |-> (sample_out == '0));

  a_r6_pos_held: assert property (@(posedge smp_clk) disable iff (rst)
    (stop || (!playing && !play)) |=> $stable(rd_addr));

  a_r5_zero_step: assert property (@(posedge smp_clk) disable iff (rst)
    (speed == '0) |=> $stable(half_sel));

  a_r9_wr_half_reset: assert property (@(posedge wr_clk)
    wr_rst |=> !wr_half_sel);

endmodule

bind dbsp_player dbsp_player_chk #(
  .ADDR_W   (ADDR_W),
  .SAMPLE_W (SAMPLE_W),
  .SPEED_W  (SPEED_W)
) chk_i (
  .smp_clk     (smp_clk),
  .rst         (rst),
  .play        (play),
  .stop        (stop),
  .speed       (speed),
  .playing     (playing),
  .sample_out  (sample_out),
  .half_sel    (half_sel),
  .rd_addr     (rd_addr),
  .wr_clk      (wr_clk),
  .wr_rst      (wr_rst),
  .wr_half_sel (wr_half_sel)
);

// File: tb/dbsp_player_tb_top.sv
module dbsp_player_tb_top;

  localparam int SMP_PERIOD = 40;
  localparam int WR_PERIOD  = 10;
  localparam int DEPTH      = 1024;

  logic        smp_clk, rst, play, stop;
  logic [3:0]  speed;
  logic        playing, half_sel, wr_half_sel;
  logic [15:0] sample_out;
  logic        wr_clk, wr_rst, wr_en;
  logic [9:0]  wr_addr;
  logic [15:0] wr_data;

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [15:0] mem_m [DEPTH];
  int          exp_addr = 0;
  logic        exp_play = 1'b0;
  logic [15:0] exp_samp = '0;

  dbsp_player dut_i (
    .smp_clk(smp_clk), .rst(rst), .play(play), .stop(stop), .speed(speed),
    .playing(playing), .sample_out(sample_out), .half_sel(half_sel),
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_half_sel(wr_half_sel)
  );

  initial smp_clk = 1'b0;
  always #(SMP_PERIOD/2) smp_clk = ~smp_clk;

  initial begin
    wr_clk = 1'b0;
    #2;
    forever #(WR_PERIOD/2) wr_clk = ~wr_clk;
  end

  function automatic logic [15:0] pat(int a, logic [15:0] salt);
    return 16'(a * 40503) ^ salt;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one sample clock: inputs are already set at a negedge
  task automatic step(string tag);
    logic pn;
    @(posedge smp_clk);
    if (rst) begin
      exp_play = 1'b0; exp_samp = '0; exp_addr = 0;
    end else begin
      pn = stop ? 1'b0 : (play ? 1'b1 : exp_play);
      exp_samp = pn ? mem_m[exp_addr] : 16'h0;
      if (pn) exp_addr = (exp_addr + int'(speed)) % DEPTH;
      exp_play = pn;
    end
    @(negedge smp_clk);
    check(tag, "playing", 32'(playing), 32'(exp_play));
    check(tag, "sample_out", 32'(sample_out), 32'(exp_samp));
    check(tag, "half_sel", 32'(half_sel), 32'(exp_addr >= DEPTH/2));
    check("R9", "wr_half_sel", 32'(wr_half_sel), 32'(exp_addr >= DEPTH/2));
  endtask

  task automatic wr_word(int a, logic [15:0] d, logic en);
    @(negedge wr_clk);
    wr_en = en; wr_addr = 10'(a); wr_data = d;
    @(posedge wr_clk);
    if (en) mem_m[a] = d;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_rst = 1'b1; play = 0; stop = 0; speed = 4'd1;
    wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge smp_clk);
    check("R9", "wr_half_sel in reset", 32'(wr_half_sel), 32'd0);
    check("R1", "playing in reset", 32'(playing), 32'd0);
    check("R1", "sample in reset", 32'(sample_out), 32'd0);
    check("R1", "half in reset", 32'(half_sel), 32'd0);
    rst = 1'b0; wr_rst = 1'b0;
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) wr_word(a, pat(a, 16'h1234), 1'b1);
    // R10: strobe low must not change entry 3
    wr_word(3, 16'hDEAD, 1'b0);
    check("R10", "model entry 3 unchanged", 32'(mem_m[3]), 32'(pat(3, 16'h1234)));
  endtask

  task automatic t_linear();
    @(negedge smp_clk);
    speed = 4'd1; play = 1'b1;
    step("R2");
    play = 1'b0;
    // runs through entry 3 (R10), crosses halves (R8) and wraps (R4)
    for (int i = 0; i < 1100; i++) step("R4");
    check("R4", "position after wrap", 32'(exp_addr), 32'd77);
  endtask

  task automatic t_stop();
    stop = 1'b1;
    step("R6");
    stop = 1'b0;
    for (int i = 0; i < 3; i++) step("R6");
    play = 1'b1;
    step("R6");
    check("R6", "resumed sample", 32'(sample_out), 32'(pat(77, 16'h1234)));
    play = 1'b0;
  endtask

  task automatic t_speed();
    speed = 4'd3;
    for (int i = 0; i < 400; i++) step("R5");
    speed = 4'd0;
    for (int i = 0; i < 5; i++) step("R5");
    speed = 4'd15;
    for (int i = 0; i < 150; i++) step("R5");
    speed = 4'd1;
  endtask

  task automatic t_priority();
    play = 1'b1; stop = 1'b1;
    step("R7");
    play = 1'b0; stop = 1'b0;
    step("R7");
  endtask

  task automatic t_refill();
    play = 1'b1;
    step("R3");
    play = 1'b0;
    while (exp_addr != DEPTH/2) step("R3");
    fork
      for (int a = 0; a < DEPTH/2; a++) wr_word(a, pat(a, 16'h5A5A), 1'b1);
      for (int i = 0; i < DEPTH/2; i++) step("R11");
    join
    for (int i = 0; i < 300; i++) step("R11");
    check("R11", "lower half rewritten", 32'(mem_m[100]), 32'(pat(100, 16'h5A5A)));
  endtask

  task automatic t_reset_mid();
    rst = 1'b1; play = 1'b1;
    step("R1");
    rst = 1'b0; play = 1'b0;
    step("R1");
  endtask

  initial begin
    #(SMP_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mem_m[a] = '0;
    t_reset();
    t_fill();
    t_linear();
    t_stop();
    t_speed();
    t_priority();
    t_refill();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule